// File: doc/BRIEF.md
# Text Pack Buffer with Serial Readout

This block sits behind a subcode receiver and gathers the six-bit text symbols of one pack. A pack is 24 symbols, which is 144 bits or 18 bytes. The block joins the symbols into bytes and writes each byte into a small two-port memory. At the same time it feeds each byte to a running CRC checker. The last two bytes of a pack hold the check word, so the pass or fail result is known as soon as the 24th symbol arrives.

When the pack is complete, the block pulls an active-low ready line low for a fixed number of clock cycles. It also places the check result on a serial data line, and that result stays there until the host gives its first shift clock. The host then clocks the 16 payload bytes out, one bit for each falling edge of its shift clock. The 128 bits give the most significant bit first and byte 0 first.

A separate sync-protection circuit reports a pack that was assembled across a doubtful block sync. It does this by raising a flag during assembly. Such a pack always reports a failed check, even when its CRC matches. The receiver signals the start of each pack with a marker pulse. Sync recovery and symbol reception are handled outside this block.

Top module: `text_pack_reader`

## Requirements
- R1: After reset, `ready_n` is high and `sdata` is low.
- R2: The block ignores symbols that arrive before the first `pack_start` after reset, and symbols that arrive after the 24th symbol of a pack until the next `pack_start`. These symbols raise no ready and leave the stored pack and its flag unchanged.
- R3: Symbols are joined into one bit stream in arrival order, each symbol most significant bit first. Byte k of the pack is stream bits 8k to 8k+7, and the earliest of these bits is the byte's bit 7.
- R4: The CRC is 16 bits with polynomial x^16+x^12+x^5+1 and an initial value of zero. It runs over bytes 0 to 15, most significant bit first. It passes when byte 16 equals the inverted high CRC byte and byte 17 equals the inverted low CRC byte.
- R5: When a pack completes, `ready_n` goes low within a few cycles of the last symbol. It stays low for exactly READY_CYC clock cycles and then returns high.
- R6: From the moment a pack completes until the first falling edge of `rd_clk`, `sdata` shows the check flag. The flag is 1 when the check passes.
- R7: The next 128 falling edges of `rd_clk` each present one payload bit on `sdata`: byte 0 to byte 15, bit 7 to bit 0 within each byte. The check bytes are never shifted out.
- R8: `sdata` is 0 when no pack has completed since reset, and also after the 128th payload bit has been followed by a further falling edge of `rd_clk`.
- R9: If `sync_bad` is high in any cycle from `pack_start` to the last symbol, the flag of that pack is 0 whatever its CRC. The next `pack_start` with `sync_bad` low clears this condition.
- R10: A `pack_start` in the middle of a pack drops the partial pack, and assembly begins again from symbol 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pack_start | input | 1 | One-cycle marker that opens a new pack |
| sym_valid | input | 1 | Qualifies `sym_data` for one cycle |
| sym_data | input | 6 | One text symbol |
| sync_bad | input | 1 | Sync-protection warning for the pack being assembled |
| rd_clk | input | 1 | Host shift clock, idle high, sampled by `clk` |
| ready_n | output | 1 | Active-low pack-ready pulse |
| sdata | output | 1 | Check flag, then the payload bits |

## Verification
The block is fed several payload patterns: an incrementing ramp, all zeros, all ones and an alternating pattern. Among these, all zeros checks the zero-init CRC against inverted check bytes of 0xFF, and the ramp exposes any error in the bit order of the packing. A corrupted check byte and a raised `sync_bad` each have to clear the flag while the payload still comes out intact. Stray symbols before the first marker, symbols after the 24th and a marker in the middle of a pack each test that the block resynchronises correctly. Extra shift edges before a pack completes and after the 128th bit test that `sdata` stays quiet.

// File: rtl/tpk_pkg.sv
package tpk_pkg;
  localparam int SYM_W      = 6;
  localparam int BYTE_W     = 8;
  localparam int PACK_SYMS  = 24;
  localparam int PACK_BYTES = 18;
  localparam int PAY_BYTES  = 16;
  localparam int PAY_BITS   = PAY_BYTES * BYTE_W;
  localparam int CRC_W      = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {PH_S0, PH_S1, PH_S2, PH_S3} sym_phase_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (r[CRC_W-1] ^ d[i]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/tpk_sym_packer.sv
module tpk_sym_packer
  import tpk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pack_start,
  input  logic                sym_valid,
  input  logic [SYM_W-1:0]    sym_data,
  input  logic                sync_bad,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [BYTE_W-1:0]   wr_data,
  output logic                bad
);
  localparam int SCNT_W = $clog2(PACK_SYMS + 1);
  localparam logic [SCNT_W-1:0] SCNT_DONE = SCNT_W'(PACK_SYMS);

  logic [SCNT_W-1:0] sym_cnt_q, sym_cnt_d;
  sym_phase_e        phase_q, phase_d;
  logic [SYM_W-1:0]  hold_q, hold_d;
  logic [ADDR_W-1:0] bcnt_q, bcnt_d;
  logic              wr_en_d;
  logic [ADDR_W-1:0] wr_addr_d;
  logic [BYTE_W-1:0] wr_data_d;
  logic              bad_d;
  logic              open_pack;

  assign open_pack = (sym_cnt_q < SCNT_DONE);

  always_comb begin
    sym_cnt_d = sym_cnt_q;
    phase_d   = phase_q;
    hold_d    = hold_q;
    bcnt_d    = bcnt_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr;
    wr_data_d = wr_data;
    bad_d     = bad | sync_bad;
    if (pack_start) begin
      sym_cnt_d = '0;
      phase_d   = PH_S0;
      bcnt_d    = '0;
      bad_d     = sync_bad;
    end else if (sym_valid && open_pack) begin
      sym_cnt_d = sym_cnt_q + 1'b1;
      unique case (phase_q)
        PH_S0: begin
          hold_d  = sym_data;
          phase_d = PH_S1;
        end
        PH_S1: begin
          wr_en_d   = 1'b1;
          wr_data_d = {hold_q, sym_data[5:4]};
          hold_d    = {2'b00, sym_data[3:0]};
          phase_d   = PH_S2;
        end
        PH_S2: begin
          wr_en_d   = 1'b1;
          wr_data_d = {hold_q[3:0], sym_data[5:2]};
          hold_d    = {4'b0000, sym_data[1:0]};
          phase_d   = PH_S3;
        end
        default: begin
          wr_en_d   = 1'b1;
          wr_data_d = {hold_q[1:0], sym_data};
          phase_d   = PH_S0;
        end
      endcase
      if (wr_en_d) begin
        wr_addr_d = bcnt_q;
        bcnt_d    = bcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_cnt_q <= SCNT_DONE;
      phase_q   <= PH_S0;
      hold_q    <= '0;
      bcnt_q    <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      bad       <= 1'b0;
    end else begin
      sym_cnt_q <= sym_cnt_d;
      phase_q   <= phase_d;
      hold_q    <= hold_d;
      bcnt_q    <= bcnt_d;
      wr_en     <= wr_en_d;
      wr_addr   <= wr_addr_d;
      wr_data   <= wr_data_d;
      bad       <= bad_d;
    end
  end

  // R3: a pack never writes past its 18 bytes
  a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < ADDR_W'(PACK_BYTES)));

  // R2: a closed pack accepts no symbol
  a_r2_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_cnt_q == SCNT_DONE && !pack_start) |=> !wr_en);
endmodule

// File: rtl/tpk_crc_chk.sv
module tpk_crc_chk
  import tpk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic                done,
  output logic                pass
);
  localparam logic [ADDR_W-1:0] A_FIRST = '0;
  localparam logic [ADDR_W-1:0] A_CHK_H = ADDR_W'(PAY_BYTES);
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(PACK_BYTES - 1);

  logic [CRC_W-1:0]  crc_q, crc_d;
  logic [BYTE_W-1:0] chk_hi_q, chk_hi_d;
  logic              done_d, pass_d;

  always_comb begin
    crc_d    = crc_q;
    chk_hi_d = chk_hi_q;
    done_d   = 1'b0;
    pass_d   = pass;
    if (wr_en) begin
      if (wr_addr == A_FIRST)      crc_d = crc_step('0, wr_data);
      else if (wr_addr < A_CHK_H)  crc_d = crc_step(crc_q, wr_data);
      else if (wr_addr == A_CHK_H) chk_hi_d = wr_data;
      else if (wr_addr == A_LAST) begin
        done_d = 1'b1;
        pass_d = (crc_q == ~{chk_hi_q, wr_data});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= '0;
      chk_hi_q <= '0;
      done     <= 1'b0;
      pass     <= 1'b0;
    end else begin
      crc_q    <= crc_d;
      chk_hi_q <= chk_hi_d;
      done     <= done_d;
      pass     <= pass_d;
    end
  end

  // R4: completion only follows the write of the last check byte
  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en && wr_addr == A_LAST));

  // R4: completion is a single-cycle event
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/tpk_pack_ram.sv
module tpk_pack_ram #(
  parameter int DEPTH  = 32,
  parameter int DW     = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tpk_read_port.sv
module tpk_read_port
  import tpk_pkg::*;
#(
  parameter int READY_CYC = 64,
  parameter int ADDR_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done,
  input  logic                pass,
  input  logic                bad,
  input  logic                rd_clk,
  input  logic [BYTE_W-1:0]   rdata,
  output logic [ADDR_W-1:0]   raddr,
  output logic                ready_n,
  output logic                sdata
);
  localparam int CNT_W = $clog2(READY_CYC + 1);
  localparam int IDX_W = $clog2(PAY_BITS + 2);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAY_BITS);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(PAY_BITS + 1);

  logic             rs1_q, rs2_q, rs3_q, fall;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d, pos;
  logic             active_q, active_d;
  logic             flag_q, flag_d;
  logic             sdata_d;

  assign fall    = rs3_q & ~rs2_q;
  assign pos     = idx_q - 1'b1;
  assign raddr   = ADDR_W'(pos >> 3);
  assign ready_n = (cnt_q == '0);

  always_comb begin
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    active_d = active_q;
    flag_d   = flag_q;
    if (done) begin
      cnt_d    = CNT_W'(READY_CYC);
      idx_d    = '0;
      active_d = 1'b1;
      flag_d   = pass & ~bad;
    end else begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      if (active_q && fall && idx_q <= IDX_LAST) idx_d = idx_q + 1'b1;
    end
  end

  always_comb begin
    if (!active_q)              sdata_d = 1'b0;
    else if (idx_q == '0)       sdata_d = flag_q;
    else if (idx_q <= IDX_LAST) sdata_d = rdata[3'd7 - pos[2:0]];
    else                        sdata_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q    <= 1'b1;
      rs2_q    <= 1'b1;
      rs3_q    <= 1'b1;
      cnt_q    <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      flag_q   <= 1'b0;
      sdata    <= 1'b0;
    end else begin
      rs1_q    <= rd_clk;
      rs2_q    <= rs1_q;
      rs3_q    <= rs2_q;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      active_q <= active_d;
      flag_q   <= flag_d;
      sdata    <= sdata_d;
    end
  end

  // R5: a completed pack pulls ready low on the next cycle
  a_r5_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ready_n);

  // R8: the bit index never runs past the end marker
  a_r8_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_END);

  // R8: no output before any pack has completed
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> !sdata);

  // R9: a pack flagged by sync protection never reports a pass
  a_r9_bad_forces_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bad) |=> !flag_q);

  // R6: while no shift edge has arrived the line shows the flag
  a_r6_flag_shown: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && idx_q == '0) |=> (sdata == $past(flag_q)));
endmodule

// File: rtl/text_pack_reader.sv
module text_pack_reader
  import tpk_pkg::*;
#(
  parameter int READY_CYC = 64,
  parameter int RAM_DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pack_start,
  input  logic             sym_valid,
  input  logic [5:0]       sym_data,
  input  logic             sync_bad,
  input  logic             rd_clk,
  output logic             ready_n,
  output logic             sdata
);
  localparam int ADDR_W = $clog2(RAM_DEPTH);

  logic              wr_en, bad, done, pass;
  logic [ADDR_W-1:0] wr_addr, raddr;
  logic [BYTE_W-1:0] wr_data, rdata;

  tpk_sym_packer #(.ADDR_W(ADDR_W)) u_packer (
    .clk(clk), .rst_n(rst_n), .pack_start(pack_start), .sym_valid(sym_valid),
    .sym_data(sym_data), .sync_bad(sync_bad), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bad(bad)
  );

  tpk_crc_chk #(.ADDR_W(ADDR_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .pass(pass)
  );

  tpk_pack_ram #(.DEPTH(RAM_DEPTH), .DW(BYTE_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(raddr), .rdata(rdata)
  );

  tpk_read_port #(.READY_CYC(READY_CYC), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .done(done), .pass(pass), .bad(bad),
    .rd_clk(rd_clk), .rdata(rdata), .raddr(raddr), .ready_n(ready_n),
    .sdata(sdata)
  );

  // R1: outputs idle while reset is held
  always_comb begin
    if (!rst_n) a_r1_reset_idle: assert (ready_n && !sdata);
  end
endmodule

// File: tb/text_pack_reader_test.sv
`timescale 1ns/1ps
module text_pack_reader_test;
  localparam int READY_CYC = 64;

  logic clk, rst_n, pack_start, sym_valid, sync_bad, rd_clk;
  logic [5:0] sym_data;
  logic ready_n, sdata;

  int total = 0;
  int bad_cnt = 0;

  typedef struct {
    logic         flag;
    logic [127:0] bits;
    string        tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] pk [18];

  text_pack_reader #(.READY_CYC(READY_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .pack_start(pack_start), .sym_valid(sym_valid),
    .sym_data(sym_data), .sync_bad(sync_bad), .rd_clk(rd_clk),
    .ready_n(ready_n), .sdata(sdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [127:0] v);
    logic [15:0] c = 16'h0000;
    for (int i = 127; i >= 0; i--) begin
      logic fb = c[15] ^ v[i];
      c = c << 1;
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  // build a pack; corrupt flips one check bit
  task automatic build(input int mode, input bit corrupt);
    logic [127:0] v;
    logic [15:0] c;
    for (int i = 0; i < 16; i++) begin
      case (mode)
        0: pk[i] = 8'(i * 17 + 3);
        1: pk[i] = 8'h00;
        2: pk[i] = 8'hFF;
        default: pk[i] = 8'hA5 ^ 8'(i);
      endcase
      v[127 - 8*i -: 8] = pk[i];
    end
    c = ref_crc(v);
    pk[16] = ~c[15:8];
    pk[17] = ~c[7:0] ^ {7'd0, corrupt};
  endtask

  function automatic logic [127:0] payload();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[127 - 8*i -: 8] = pk[i];
    return v;
  endfunction

  task automatic push_exp(input logic flag, input string tag);
    exp_t e;
    e.flag = flag;
    e.bits = payload();
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // driver: marker, then nsym symbols from pk; bad_at raises sync_bad on that symbol
  task automatic send(input int nsym, input int bad_at, input bit marker);
    logic [143:0] s;
    for (int i = 0; i < 18; i++) s[143 - 8*i -: 8] = pk[i];
    if (marker) begin
      @(negedge clk); pack_start = 1'b1;
      @(negedge clk); pack_start = 1'b0;
    end
    for (int i = 0; i < nsym; i++) begin
      @(negedge clk);
      sym_valid = 1'b1;
      sym_data  = (i < 24) ? s[143 - 6*i -: 6] : 6'(i * 7);
      sync_bad  = (i == bad_at);
    end
    @(negedge clk);
    sym_valid = 1'b0;
    sync_bad  = 1'b0;
  endtask

  task automatic rd_edge();
    rd_clk = 1'b0;
    repeat (6) @(negedge clk);
    rd_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops the oldest expected pack and compares the serial stream
  task automatic read_pack();
    exp_t e;
    logic [127:0] got;
    e = sb.pop_front();
    check(sdata === e.flag, {"R6 R4 R9 flag ", e.tag}, 128'(sdata), 128'(e.flag));
    for (int b = 127; b >= 0; b--) begin
      rd_clk = 1'b0;
      repeat (6) @(negedge clk);
      got[b] = sdata;
      rd_clk = 1'b1;
      repeat (4) @(negedge clk);
    end
    check(got === e.bits, {"R3 R7 payload ", e.tag}, got, e.bits);
    rd_edge();
    check(sdata === 1'b0, {"R8 after last bit ", e.tag}, 128'(sdata), 128'd0);
  endtask

  task automatic wait_ready(input string tag);
    repeat (6) @(negedge clk);
    check(ready_n === 1'b0, {"R5 ready low ", tag}, 128'(ready_n), 128'd0);
  endtask

  initial begin
    int lowc;
    rst_n = 1'b0; pack_start = 1'b0; sym_valid = 1'b0; sync_bad = 1'b0;
    rd_clk = 1'b1; sym_data = '0;
    repeat (3) @(negedge clk);
    check(ready_n === 1'b1 && sdata === 1'b0, "R1 reset state",
          128'({ready_n, sdata}), 128'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: symbols before any marker are dropped; R8: shift edge with no pack
    build(0, 1'b0);
    send(30, -1, 1'b0);
    repeat (10) @(negedge clk);
    check(ready_n === 1'b1, "R2 no ready without marker", 128'(ready_n), 128'd1);
    rd_edge();
    check(sdata === 1'b0, "R8 idle line quiet", 128'(sdata), 128'd0);

    // R5: ramp pack, measure the ready pulse width
    build(0, 1'b0);
    push_exp(1'b1, "ramp");
    send(24, -1, 1'b1);
    lowc = 0;
    for (int k = 0; k < READY_CYC + 40; k++) begin
      @(negedge clk);
      if (ready_n === 1'b0) lowc++;
    end
    check(lowc == READY_CYC, "R5 ready width", 128'(lowc), 128'(READY_CYC));
    check(ready_n === 1'b1, "R5 ready back high", 128'(ready_n), 128'd1);
    read_pack();

    // R4: all zeros payload, check bytes 0xFF
    build(1, 1'b0);
    push_exp(1'b1, "zeros");
    send(24, -1, 1'b1);
    wait_ready("zeros");
    read_pack();

    // R4: all ones payload
    build(2, 1'b0);
    push_exp(1'b1, "ones");
    send(24, -1, 1'b1);
    wait_ready("ones");
    read_pack();

    // R4: corrupted check byte gives flag 0
    build(3, 1'b1);
    push_exp(1'b0, "corrupt");
    send(24, -1, 1'b1);
    wait_ready("corrupt");
    read_pack();

    // R9: sync warning mid-pack forces flag 0 on a valid pack
    build(3, 1'b0);
    push_exp(1'b0, "sync_bad");
    send(24, 10, 1'b1);
    wait_ready("sync_bad");
    read_pack();

    // R9: next clean pack passes again
    build(0, 1'b0);
    push_exp(1'b1, "after_bad");
    send(24, -1, 1'b1);
    wait_ready("after_bad");
    read_pack();

    // R10: marker in the middle of a pack restarts it
    build(2, 1'b0);
    send(10, -1, 1'b1);
    repeat (10) @(negedge clk);
    check(ready_n === 1'b1, "R10 partial pack no ready", 128'(ready_n), 128'd1);
    build(3, 1'b0);
    push_exp(1'b1, "restart");
    send(24, -1, 1'b1);
    wait_ready("restart");
    read_pack();

    // R2: symbols after the 24th do not disturb the stored pack
    build(1, 1'b0);
    push_exp(1'b1, "extra");
    send(30, -1, 1'b1);
    repeat (2) @(negedge clk);
    check(ready_n === 1'b0, "R2 ready with extra symbols", 128'(ready_n), 128'd0);
    read_pack();

    $display("test done: total=%0d bad=%0d", total, bad_cnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad_cnt++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad_cnt);
    $finish;
  end
endmodule